// File: doc/BRIEF.md
# Serial NAND Identification Reader

This block reads the identity bytes of a serial NAND device over a single-line SPI-style link (clock idle low, data launched while the clock is low and sampled on its rising edge). On a start pulse it selects the device, shifts out the identification opcode 0x9F and then frames the response in one of several ways. With the plain framing the identity bytes follow the opcode at once. With the address framing one zero address byte comes first. With the dummy framing one dummy byte comes first, and whatever the device returns during it is thrown away. It then collects a configurable number of identity bytes, at most `ID_MAX`.

Once capture ends, the block compares the collected bytes with a small table of expected identities. Each table entry carries its own byte count and the framing under which it is valid. The block reports whether any entry matched and the index of the matching entry, and it keeps the collected bytes on an output bus until the next read. A start pulse that arrives during a read has no effect.

Top module: `nid_id_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy, done and id_match are 0, and match_idx and id_bytes are all zero.
- R2: Each read first shifts out the opcode 0x9F, MSB first. sclk idles low. mosi changes only while sclk is low, and miso is sampled on the rising edge of sclk.
- R3: rd_method, sampled at start, selects the framing. 0 = opcode only. 1 = one address byte 0x00. 2 = one dummy byte, driven as 0x00 with its received data discarded. 3 = same wire framing as 0. A read clocks exactly 8 × (1 + pre + n) bits, where pre is 1 for codes 1 and 2 and 0 otherwise, and n is the capture length.
- R4: The capture length n is rd_len sampled at start. A value of 0 gives 1, and a value above ID_MAX gives ID_MAX. The k-th received identity byte (k from 0) appears at id_bytes[8k+7:8k].
- R5: Bytes of id_bytes at positions n and above read as zero after a read. All of id_bytes is cleared when a read starts.
- R6: Table entry e matches only when all of these hold: its method field (tbl_method[2e+1:2e]) equals the sampled rd_method; its length (tbl_len[LEN_W·e +: LEN_W]) is between 1 and n; and its first length bytes (tbl_id byte e·ID_MAX+b) equal the received bytes.
- R7: When several entries match, the one with the lowest index wins, and its index is given on match_idx.
- R8: When no entry matches, id_match is 0 and match_idx is 0.
- R9: A start pulse while busy is 1 is ignored. It changes neither the framing, the bit count, the captured bytes nor the match result of the read in progress.
- R10: done is a single-cycle pulse. It comes one cycle after cs_n returns high, and at that point busy is 0. id_match and match_idx are valid from done onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an identification read (one cycle) |
| rd_method | input | 2 | Framing code, see R3 |
| rd_len | input | LEN_W | Requested identity byte count |
| tbl_id | input | TBL_N·ID_MAX·8 | Expected identity bytes, entry-major |
| tbl_len | input | TBL_N·LEN_W | Byte count for each entry |
| tbl_method | input | TBL_N·2 | Framing code for each entry |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Device select, active low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| busy | output | 1 | Read in progress |
| done | output | 1 | Read finished pulse |
| id_bytes | output | ID_MAX·8 | Captured identity bytes, byte 0 lowest |
| id_match | output | 1 | A table entry matched |
| match_idx | output | IDX_W | Index of the matching entry |

## Verification
The bench builds the block with its defaults: ID_MAX = 5, a four-entry table, a 3-bit length field and a 2-bit index. With a 3-bit rd_len, the values 0, 6 and 7 can be driven, so both sides of the length clamp are exercised. Four entries are enough to place two matching entries side by side to test priority. They also allow an entry whose bytes agree but whose length exceeds the capture, next to entries whose method alone differs. A behavioural device on the serial pins logs the opcode and preamble bits and counts clock edges for every framing code, including code 3.

// File: rtl/nid_pkg.sv
`timescale 1ns/1ps
package nid_pkg;

    localparam logic [7:0] RDID_OPCODE = 8'h9F;
    localparam int         BYTE_W      = 8;

    typedef enum logic [1:0] {
        FRM_PLAIN = 2'd0,
        FRM_ADDR  = 2'd1,
        FRM_DUMMY = 2'd2,
        FRM_ALT   = 2'd3
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_PRE,
        ST_DATA,
        ST_FIN
    } rd_state_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] idx;
    } match_res_t;

    function automatic logic frame_has_pre(input logic [1:0] m);
        return (m == FRM_ADDR) || (m == FRM_DUMMY);
    endfunction

endpackage

// File: rtl/nid_shifter.sv
`timescale 1ns/1ps
module nid_shifter
    import nid_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int CW = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [BW-1:0] tx_byte,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic [BW-1:0] rx_byte,
    output logic          byte_done
);
    logic          active;
    logic          phase;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] tx_sh;
    logic [BW-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            phase     <= 1'b0;
            bit_cnt   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            sclk      <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    phase   <= 1'b0;
                    bit_cnt <= '0;
                    tx_sh   <= tx_byte;
                    sclk    <= 1'b0;
                end
            end else if (!phase) begin
                sclk  <= 1'b1;
                rx_sh <= {rx_sh[BW-2:0], miso};
                phase <= 1'b1;
            end else begin
                sclk  <= 1'b0;
                phase <= 1'b0;
                tx_sh <= {tx_sh[BW-2:0], 1'b0};
                if (bit_cnt == CW'(BW - 1)) begin
                    active    <= 1'b0;
                    byte_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + CW'(1);
                end
            end
        end
    end

    assign mosi    = tx_sh[BW-1];
    assign rx_byte = rx_sh;

endmodule

// File: rtl/nid_ctrl.sv
`timescale 1ns/1ps
module nid_ctrl
    import nid_pkg::*;
#(
    parameter int ID_MAX = 5,
    parameter int LEN_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic [1:0]            method_in,
    input  logic [LEN_W-1:0]      len_in,
    input  logic                  sh_done,
    input  logic [7:0]            sh_rx,
    output logic                  sh_start,
    output logic [7:0]            sh_tx,
    output logic                  cs_n,
    output logic                  busy,
    output logic                  fin,
    output logic [LEN_W-1:0]      cap_len,
    output logic [1:0]            cap_method,
    output logic [ID_MAX*8-1:0]   cap_id
);
    rd_state_e          st;
    logic [LEN_W-1:0]   cnt;
    logic [LEN_W-1:0]   clen;
    logic [1:0]         cm;
    logic [ID_MAX*8-1:0] id_q;
    logic               last_byte;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l == '0)
            return LEN_W'(1);
        else if (l > LEN_W'(ID_MAX))
            return LEN_W'(ID_MAX);
        else
            return l;
    endfunction

    assign last_byte = ((cnt + LEN_W'(1)) == clen);

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        unique case (st)
            ST_IDLE: begin
                sh_start = req;
                sh_tx    = RDID_OPCODE;
            end
            ST_OPC:  sh_start = sh_done;
            ST_PRE:  sh_start = sh_done;
            ST_DATA: sh_start = sh_done && !last_byte;
            default: sh_start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
            cnt  <= '0;
            clen <= LEN_W'(1);
            cm   <= '0;
            id_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req) begin
                    st   <= ST_OPC;
                    cs_n <= 1'b0;
                    clen <= clamp_len(len_in);
                    cm   <= method_in;
                    id_q <= '0;
                    cnt  <= '0;
                end
                ST_OPC: if (sh_done)
                    st <= frame_has_pre(cm) ? ST_PRE : ST_DATA;
                ST_PRE: if (sh_done)
                    st <= ST_DATA;
                ST_DATA: if (sh_done) begin
                    for (int b = 0; b < ID_MAX; b++) begin
                        if (b == int'(cnt))
                            id_q[b*8 +: 8] <= sh_rx;
                    end
                    if (last_byte) begin
                        st   <= ST_FIN;
                        cs_n <= 1'b1;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign fin        = (st == ST_FIN);
    assign cap_len    = clen;
    assign cap_method = cm;
    assign cap_id     = id_q;

endmodule

// File: rtl/nid_match.sv
`timescale 1ns/1ps
module nid_match
    import nid_pkg::*;
#(
    parameter int ID_MAX = 5,
    parameter int TBL_N  = 4,
    parameter int LEN_W  = 3,
    parameter int IDX_W  = 2
) (
    input  logic [ID_MAX*8-1:0]       cap_id,
    input  logic [LEN_W-1:0]          cap_len,
    input  logic [1:0]                cap_method,
    input  logic [TBL_N*ID_MAX*8-1:0] tbl_id,
    input  logic [TBL_N*LEN_W-1:0]    tbl_len,
    input  logic [TBL_N*2-1:0]        tbl_method,
    output logic                      hit_any,
    output logic [IDX_W-1:0]          hit_idx
);
    logic [TBL_N-1:0] hit;

    for (genvar e = 0; e < TBL_N; e++) begin : g_ent
        logic [LEN_W-1:0] elen;
        logic             bytes_eq;

        assign elen = tbl_len[e*LEN_W +: LEN_W];

        always_comb begin
            bytes_eq = 1'b1;
            for (int b = 0; b < ID_MAX; b++) begin
                if (b < int'(elen) &&
                    tbl_id[(e*ID_MAX + b)*8 +: 8] != cap_id[b*8 +: 8])
                    bytes_eq = 1'b0;
            end
        end

        assign hit[e] = (tbl_method[e*2 +: 2] == cap_method) &&
                        (elen != '0) && (elen <= cap_len) && bytes_eq;
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int e = TBL_N - 1; e >= 0; e--) begin
            if (hit[e]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/nid_id_reader.sv
`timescale 1ns/1ps
module nid_id_reader
    import nid_pkg::*;
#(
    parameter int ID_MAX = 5,
    parameter int TBL_N  = 4,
    localparam int LEN_W = $clog2(ID_MAX + 1),
    localparam int IDX_W = (TBL_N > 1) ? $clog2(TBL_N) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [1:0]                rd_method,
    input  logic [LEN_W-1:0]          rd_len,
    input  logic [TBL_N*ID_MAX*8-1:0] tbl_id,
    input  logic [TBL_N*LEN_W-1:0]    tbl_len,
    input  logic [TBL_N*2-1:0]        tbl_method,
    output logic                      sclk,
    output logic                      cs_n,
    output logic                      mosi,
    input  logic                      miso,
    output logic                      busy,
    output logic                      done,
    output logic [ID_MAX*8-1:0]       id_bytes,
    output logic                      id_match,
    output logic [IDX_W-1:0]          match_idx
);
    logic             sh_start;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;
    logic             sh_done;
    logic             fin;
    logic [LEN_W-1:0] cap_len;
    logic [1:0]       cap_method;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;

    nid_shifter #(.BW(8)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_byte   (sh_rx),
        .byte_done (sh_done)
    );

    nid_ctrl #(.ID_MAX(ID_MAX), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (start),
        .method_in  (rd_method),
        .len_in     (rd_len),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx),
        .sh_start   (sh_start),
        .sh_tx      (sh_tx),
        .cs_n       (cs_n),
        .busy       (busy),
        .fin        (fin),
        .cap_len    (cap_len),
        .cap_method (cap_method),
        .cap_id     (id_bytes)
    );

    nid_match #(.ID_MAX(ID_MAX), .TBL_N(TBL_N), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_match (
        .cap_id     (id_bytes),
        .cap_len    (cap_len),
        .cap_method (cap_method),
        .tbl_id     (tbl_id),
        .tbl_len    (tbl_len),
        .tbl_method (tbl_method),
        .hit_any    (hit_any),
        .hit_idx    (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            id_match  <= 1'b0;
            match_idx <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                id_match  <= hit_any;
                match_idx <= hit_idx;
            end
        end
    end

endmodule

// File: rtl/nid_reader_chk.sv
`timescale 1ns/1ps
module nid_reader_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             sclk,
    input logic             cs_n,
    input logic             mosi,
    input logic             busy,
    input logic             done,
    input logic             id_match,
    input logic [IDX_W-1:0] match_idx
);
    // R1: device deselected whenever no read is running
    a_r1_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R2: serial clock parked low while deselected
    a_r2_sclk_parked: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R2: data out does not move on the rising clock edge
    a_r2_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $stable(mosi));

    // R8: no match reports index zero
    a_r8_idx_clear: assert property (@(posedge clk) disable iff (rst)
        !id_match |-> (match_idx == '0));

    // R9: a read begins only from a start request
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done follows deselect by one cycle
    a_r10_done_after_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> done);

    // R10: block is idle when done is shown
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind nid_id_reader nid_reader_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy),
    .done      (done),
    .id_match  (id_match),
    .match_idx (match_idx)
);

// File: tb/nid_id_reader_bench.sv
`timescale 1ns/1ps
module nid_id_reader_bench;
    localparam int ID_MAX = 5;
    localparam int TBL_N  = 4;
    localparam int LEN_W  = 3;
    localparam int IDX_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] rd_method = '0;
    logic [LEN_W-1:0] rd_len = '0;
    logic [TBL_N*ID_MAX*8-1:0] tbl_id;
    logic [TBL_N*LEN_W-1:0] tbl_len;
    logic [TBL_N*2-1:0] tbl_method;
    logic sclk, cs_n, mosi, busy, done, id_match;
    logic miso = 1'b0;
    logic [ID_MAX*8-1:0] id_bytes;
    logic [IDX_W-1:0] match_idx;

    logic [7:0]       t_id   [TBL_N][ID_MAX];
    logic [LEN_W-1:0] t_len  [TBL_N];
    logic [1:0]       t_meth [TBL_N];

    always_comb begin
        for (int e = 0; e < TBL_N; e++) begin
            tbl_len[e*LEN_W +: LEN_W] = t_len[e];
            tbl_method[e*2 +: 2]      = t_meth[e];
            for (int b = 0; b < ID_MAX; b++)
                tbl_id[(e*ID_MAX + b)*8 +: 8] = t_id[e][b];
        end
    end

    nid_id_reader #(.ID_MAX(ID_MAX), .TBL_N(TBL_N)) u_nid_id_reader (
        .clk(clk), .rst(rst), .start(start), .rd_method(rd_method), .rd_len(rd_len),
        .tbl_id(tbl_id), .tbl_len(tbl_len), .tbl_method(tbl_method),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy), .done(done),
        .id_bytes(id_bytes), .id_match(id_match), .match_idx(match_idx)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural device
    logic [7:0] dev_id [ID_MAX];
    logic [1:0] dev_meth = '0;
    int         pos_cnt = 0;
    logic [7:0] mosi_log [8];
    logic       prev_s = 1'b0;
    logic       prev_cs = 1'b1;

    function automatic logic resp_bit(input int n);
        int k = n / 8;
        int pre = (dev_meth == 2'd1 || dev_meth == 2'd2) ? 1 : 0;
        logic [7:0] v;
        if (k < 1 + pre)               v = 8'hA5;
        else if (k - 1 - pre < ID_MAX) v = dev_id[k - 1 - pre];
        else                           v = 8'h3C;
        return v[7 - (n % 8)];
    endfunction

    always @(cs_n or sclk) begin
        if (sclk && !prev_s) begin
            if (pos_cnt < 64) mosi_log[pos_cnt / 8][7 - (pos_cnt % 8)] = mosi;
            pos_cnt++;
        end else if (!sclk && prev_s) begin
            miso = resp_bit(pos_cnt);
        end else if (!cs_n && prev_cs) begin
            pos_cnt = 0;
            for (int i = 0; i < 8; i++) mosi_log[i] = 8'h77;
            miso = resp_bit(0);
        end
        prev_s  = sclk;
        prev_cs = cs_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_clen(input logic [LEN_W-1:0] rl);
        if (rl == 0) return 1;
        if (int'(rl) > ID_MAX) return ID_MAX;
        return int'(rl);
    endfunction

    function automatic int exp_hit(input logic [1:0] m, input int clen);
        for (int e = 0; e < TBL_N; e++) begin
            bit ok = (t_meth[e] == m) && (t_len[e] != 0) && (int'(t_len[e]) <= clen);
            for (int b = 0; b < ID_MAX; b++)
                if (b < int'(t_len[e]) && t_id[e][b] != dev_id[b]) ok = 0;
            if (ok) return e;
        end
        return -1;
    endfunction

    task automatic run_txn(input logic [1:0] m, input logic [LEN_W-1:0] rl, input bit poke);
        int clen = exp_clen(rl);
        int pre  = (m == 2'd1 || m == 2'd2) ? 1 : 0;
        int eh   = exp_hit(m, clen);
        int w    = 0;
        logic [ID_MAX*8-1:0] exp_id = '0;
        bit pre_ok = 1;
        dev_meth = m;
        @(negedge clk);
        rd_method = m; rd_len = rl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R10", "busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            rd_method = ~m; rd_len = 3'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        for (int b = 0; b < clen; b++) exp_id[b*8 +: 8] = dev_id[b];
        for (int b = 1; b <= pre; b++) if (mosi_log[b] !== 8'h00) pre_ok = 0;
        check(done === 1'b1, "R10", "done seen", 64'(done), 64'd1);
        check(busy === 1'b0 && cs_n === 1'b1, "R10", "idle at done", {62'd0, busy, cs_n}, 64'd1);
        check(mosi_log[0] === 8'h9F, "R2", "opcode", 64'(mosi_log[0]), 64'h9F);
        check(pre_ok, "R3", "preamble byte zero", 64'(mosi_log[1]), 64'h0);
        check(pos_cnt == 8 * (1 + pre + clen), poke ? "R9" : "R3", "clock count",
              64'(pos_cnt), 64'(8 * (1 + pre + clen)));
        check(id_bytes === exp_id, poke ? "R9" : "R4", "id bytes", 64'(id_bytes), 64'(exp_id));
        check(id_match === (eh >= 0), eh >= 0 ? "R6" : "R8", "match flag",
              64'(id_match), 64'(eh >= 0));
        check(match_idx === IDX_W'(eh >= 0 ? eh : 0), eh >= 0 ? "R7" : "R8", "match index",
              64'(match_idx), 64'(eh >= 0 ? eh : 0));
        @(negedge clk);
        check(done === 1'b0, "R10", "done pulse width", 64'(done), 64'd0);
    endtask

    task automatic set_ent(input int e, input logic [1:0] m, input int len,
                           input logic [39:0] bytes);
        t_meth[e] = m;
        t_len[e]  = LEN_W'(len);
        for (int b = 0; b < ID_MAX; b++) t_id[e][b] = bytes[b*8 +: 8];
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'h5EED_0042);
        for (int e = 0; e < TBL_N; e++) set_ent(e, 2'd0, 0, 40'd0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cs_n === 1'b1 && sclk === 1'b0, "R1", "pins after reset", {62'd0, cs_n, sclk}, 64'h2);
        check(busy === 1'b0 && done === 1'b0, "R1", "status after reset", {62'd0, busy, done}, 64'h0);
        check(id_match === 1'b0 && match_idx === '0 && id_bytes === '0, "R1", "results after reset",
              64'(id_bytes), 64'h0);

        // directed: bytes 11 22 33 44 55
        dev_id[0] = 8'h11; dev_id[1] = 8'h22; dev_id[2] = 8'h33; dev_id[3] = 8'h44; dev_id[4] = 8'h55;
        set_ent(0, 2'd1, 2, 40'h00_0000_2211);
        set_ent(1, 2'd0, 3, 40'h00_0033_2211);
        set_ent(2, 2'd0, 2, 40'h00_0000_2211);
        set_ent(3, 2'd2, 5, 40'h55_4433_2211);
        run_txn(2'd0, 3'd5, 0);   // R7 entry 1 before entry 2
        run_txn(2'd2, 3'd5, 0);   // R3 dummy framing, entry 3
        run_txn(2'd2, 3'd4, 0);   // R6 entry longer than capture
        run_txn(2'd1, 3'd2, 0);   // R3 address framing, R5 upper bytes zero
        run_txn(2'd3, 3'd5, 0);   // R3 code 3, R8 no entry
        run_txn(2'd0, 3'd0, 0);   // R4 clamp low
        run_txn(2'd0, 3'd7, 0);   // R4 clamp high
        run_txn(2'd2, 3'd5, 1);   // R9 start during read
        set_ent(1, 2'd0, 3, 40'h00_0034_2211);
        run_txn(2'd0, 3'd3, 0);   // R6 one byte differs, entry 2 wins

        // random
        for (int t = 0; t < 150; t++) begin
            logic [1:0] m = 2'($urandom % 4);
            for (int b = 0; b < ID_MAX; b++) dev_id[b] = 8'($urandom);
            for (int e = 0; e < TBL_N; e++) begin
                int kind = int'($urandom % 4);
                t_meth[e] = (kind == 3) ? 2'($urandom % 4) : m;
                t_len[e]  = LEN_W'(1 + $urandom % 5);
                for (int b = 0; b < ID_MAX; b++) t_id[e][b] = dev_id[b];
                if (kind == 1) t_id[e][$urandom % int'(t_len[e])] ^= 8'h01;
            end
            run_txn(m, LEN_W'($urandom % 8), (t % 17) == 5);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule